// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides its input clock by a programmable 15-bit ratio N. It emits a single-cycle pulse once every N input cycles. It also provides a square wave at half the pulse rate, which can be routed to a test pin.

The ratio is realised in the pulse-swallow manner. A modelled dual-modulus prescaler counts either 16 or 17 input cycles per prescaler cycle. A 4-bit swallow counter, loaded from the low four ratio bits (A), keeps the prescaler at 17 for the first A prescaler cycles of each output period. An 11-bit main counter, loaded from the upper eleven ratio bits (M), sets how many prescaler cycles make one output period. Each period therefore lasts 16·M + A input cycles.

The counters can only work when M is at least A. For this reason ratios below 240 are replaced by 240, and a sticky error flag is raised. The ratio input is sampled once per period, in its last cycle, so a change made mid-period never shortens or stretches the period in progress.

Top module: `pswDivider`

## Requirements
- R1: For a legal ratio N (240 to 32767), consecutive `divPulse` assertions are exactly N input clock cycles apart.
- R2: The period equals 16·ratio[14:4] + ratio[3:0]. The prescaler runs at modulus 17 for ratio[3:0] prescaler cycles at the start of each period and at modulus 16 for the rest, with no 17-cycle after a 16-cycle within a period. This covers a ratio whose low and upper fields are equal (255) and ratios with a nonzero low field (4097, 32767).
- R3: A ratio below 240, including 0, produces a period of exactly 240 cycles.
- R4: `ratioErr` goes high once a ratio below 240 has been taken into use. It stays high until reset. It never rises while only legal ratios are used.
- R5: `ratioIn` is sampled only in the last cycle of each output period. A change made mid-period leaves the current period at the old ratio, and the next period uses the new one.
- R6: `divPulse` is high for exactly one cycle per period.
- R7: `divHalf` inverts in the same cycle that `divPulse` is high and holds its value in every other cycle. After reset the first pulse drives it to 1.
- R8: While `rstN` is low, `divPulse`, `divHalf` and `ratioErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Active-low synchronous reset |
| ratioIn | input | 15 | Requested division ratio; bits [3:0] swallow count, bits [14:4] main count |
| divPulse | output | 1 | One-cycle pulse per output period |
| divHalf | output | 1 | Divider output divided by two, for a test pin |
| ratioErr | output | 1 | Sticky flag: a ratio below 240 was clamped |

## Verification
The assertions check, on every cycle, properties that hold cycle by cycle:
- the prescaler count stays inside its current modulus;
- once the swallow phase ends it never resumes before the next period;
- the main count holds between prescaler wraps;
- every loaded main count is at least 15;
- the pulse is one cycle wide, and the half-rate output changes only with the pulse;
- the error flag is sticky.

Exact period lengths can only be shown by the bench's scenarios. These include the 240 and 255 corners, ratio 32767, clamping of 239 and 0, and mid-period ratio changes taking effect one period later. The same holds for the error flag rising only after an illegal ratio is actually used.

// File: rtl/pswDivPkg.sv
package pswDivPkg;
  localparam int RATIO_W_DEF   = 15;
  localparam int SWALLOW_W_DEF = 4;
  localparam int MIN_RATIO_DEF = 240;

  // strobes from control to prescaler datapath
  typedef struct packed {
    logic restart;    // load counters, prescaler returns to zero
    logic use17;      // prescaler modulus select: 1 -> 17, 0 -> 16
    logic periodEnd;  // last input cycle of an output period
  } ctrlStrobes_t;
endpackage

// File: rtl/pswDivCtrl.sv
module pswDivCtrl
  import pswDivPkg::*;
#(
  parameter int RATIO_W   = RATIO_W_DEF,
  parameter int SWALLOW_W = SWALLOW_W_DEF,
  parameter int MIN_RATIO = MIN_RATIO_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioIn,
  input  logic               presWrap,
  output ctrlStrobes_t       strb,
  output logic               ratioErr
);
  localparam int MAIN_W   = RATIO_W - SWALLOW_W;
  localparam int MIN_MAIN = MIN_RATIO >> SWALLOW_W;

  logic                 primed;
  logic [SWALLOW_W-1:0] aLeft;
  logic [MAIN_W-1:0]    mLeft;
  logic                 lowRatio;
  logic [RATIO_W-1:0]   effRatio;
  logic                 endCycle;

  assign lowRatio = ratioIn < RATIO_W'(MIN_RATIO);
  assign effRatio = lowRatio ? RATIO_W'(MIN_RATIO) : ratioIn;
  assign endCycle = primed && presWrap && (mLeft == MAIN_W'(1));

  assign strb.restart   = endCycle || !primed;
  assign strb.periodEnd = endCycle;
  assign strb.use17     = (aLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed   <= 1'b0;
      aLeft    <= '0;
      mLeft    <= '0;
      ratioErr <= 1'b0;
    end else if (strb.restart) begin
      primed <= 1'b1;
      aLeft  <= effRatio[SWALLOW_W-1:0];
      mLeft  <= effRatio[RATIO_W-1:SWALLOW_W];
      if (lowRatio) ratioErr <= 1'b1;
    end else if (presWrap) begin
      mLeft <= mLeft - MAIN_W'(1);
      if (aLeft != '0) aLeft <= aLeft - SWALLOW_W'(1);
    end
  end

  // R3: every loaded main count is large enough to cover the swallow count
  p_load_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (mLeft >= MAIN_W'(MIN_MAIN)));
  // R4: error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    ratioErr |=> ratioErr);
  // R2: no modulus-17 cycle after the swallow phase within a period
  p_swallow_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.use17 && !strb.restart) |=> !strb.use17);
  // R5: main count only moves on a prescaler wrap or a period restart
  p_main_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && !presWrap) |=> $stable(mLeft));
endmodule

// File: rtl/pswDivPath.sv
module pswDivPath
  import pswDivPkg::*;
#(
  parameter int SWALLOW_W = SWALLOW_W_DEF
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  output logic         presWrap,
  output logic         divPulse,
  output logic         divHalf
);
  localparam int PRE_W    = SWALLOW_W + 1;
  localparam int PRE_BASE = 1 << SWALLOW_W;

  logic [PRE_W-1:0] preCnt;

  assign presWrap = (preCnt == (strb.use17 ? PRE_W'(PRE_BASE) : PRE_W'(PRE_BASE - 1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      divPulse <= 1'b0;
      divHalf  <= 1'b0;
    end else begin
      if (strb.restart || presWrap) preCnt <= '0;
      else                          preCnt <= preCnt + PRE_W'(1);
      divPulse <= strb.periodEnd;
      if (strb.periodEnd) divHalf <= ~divHalf;
    end
  end

  // R2: prescaler count stays inside the selected modulus
  p_pres_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.use17 |-> (preCnt <= PRE_W'(PRE_BASE - 1)));
  // R6: output pulse is a single cycle wide
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);
  // R7: half-rate output flips with each pulse
  p_half_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> (divHalf != $past(divHalf)));
  // R7: half-rate output holds between pulses
  p_half_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !divPulse |-> $stable(divHalf));
endmodule

// File: rtl/pswDivider.sv
module pswDivider
  import pswDivPkg::*;
#(
  parameter int RATIO_W   = RATIO_W_DEF,
  parameter int SWALLOW_W = SWALLOW_W_DEF,
  parameter int MIN_RATIO = MIN_RATIO_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioIn,
  output logic               divPulse,
  output logic               divHalf,
  output logic               ratioErr
);
  ctrlStrobes_t strb;
  logic         presWrap;

  pswDivCtrl #(
    .RATIO_W  (RATIO_W),
    .SWALLOW_W(SWALLOW_W),
    .MIN_RATIO(MIN_RATIO)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .ratioIn (ratioIn),
    .presWrap(presWrap),
    .strb    (strb),
    .ratioErr(ratioErr)
  );

  pswDivPath #(
    .SWALLOW_W(SWALLOW_W)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .presWrap(presWrap),
    .divPulse(divPulse),
    .divHalf (divHalf)
  );
endmodule

// File: tb/pswDivider_tb_top.sv
module pswDivider_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] ratioIn = 15'd1000;
  logic        divPulse, divHalf, ratioErr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    n;
    string tag;
  } expItem_t;
  expItem_t expQ[$];
  int curRatio = 1000;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pswDivider dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .ratioIn (ratioIn),
    .divPulse(divPulse),
    .divHalf (divHalf),
    .ratioErr(ratioErr)
  );

  function automatic int clampRef(int r);
    return (r < 240) ? 240 : r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divPulse);
  endtask

  function automatic string tagFor(int r);
    if (r < 240) return "R3 clamped period";
    if ((r % 16) != 0) return "R2 swallow period";
    return "R1 period";
  endfunction

  // driver: at each pulse push the period the ratio sampled just before it implies
  task automatic stepTo(int newVal, int nKeep);
    expItem_t it;
    waitPulse();
    it.n = clampRef(curRatio);
    it.tag = "R5 mid-period change keeps old period";
    expQ.push_back(it);
    repeat (7) @(negedge clk);
    ratioIn  = 15'(newVal);
    curRatio = newVal;
    for (int k = 0; k < nKeep; k++) begin
      waitPulse();
      it.n = clampRef(curRatio);
      it.tag = tagFor(curRatio);
      expQ.push_back(it);
    end
  endtask

  // monitor: measure pulse spacing, width and half-rate output
  initial begin
    int       lastCyc = 0;
    bit       havePrev = 1'b0;
    bit       prevPulse = 1'b0;
    int       nPulse = 0;
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (prevPulse) check(divPulse == 1'b0, "R6 pulse width", int'(divPulse), 0);
        if (divPulse) begin
          nPulse++;
          check(divHalf == nPulse[0], "R7 half-rate output", int'(divHalf), int'(nPulse[0]));
          if (havePrev && expQ.size() > 0) begin
            it = expQ.pop_front();
            check((cyc - lastCyc) == it.n, it.tag, cyc - lastCyc, it.n);
          end
          havePrev = 1'b1;
          lastCyc  = cyc;
        end
        prevPulse = divPulse;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R8 reset divPulse", int'(divPulse), 0);
    check(divHalf == 1'b0, "R8 reset divHalf", int'(divHalf), 0);
    check(ratioErr == 1'b0, "R8 reset ratioErr", int'(ratioErr), 0);
    rstN = 1'b1;
    stepTo(240, 1);
    stepTo(255, 1);
    stepTo(4097, 1);
    stepTo(32767, 0);
    check(ratioErr == 1'b0, "R4 no error for legal ratios", int'(ratioErr), 0);
    stepTo(239, 1);
    check(ratioErr == 1'b1, "R4 error after clamp", int'(ratioErr), 1);
    stepTo(0, 1);
    stepTo(500, 2);
    while (expQ.size() > 0) @(negedge clk);
    check(ratioErr == 1'b1, "R4 error sticky", int'(ratioErr), 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule